// File: doc/BRIEF.md
# Dual-Processor Shared SRAM Address Decoder

This block sits between two bus masters and one 32K x 16 SRAM. The masters are an 8-bit control CPU and a 16-bit DSP, and they also share an audio peripheral, a UART and two small control registers. Each master gets its own memory map inside the 16K page from 0x4000 to 0x7FFF. The two maps differ so that each processor can use as much of the SRAM as possible.

For each bus the block turns the address and the read/write strobes into several outputs: an SRAM chip select, a 15-bit physical SRAM word address, per-lane SRAM write enables, and peripheral selects. A bank-select input moves the CPU's whole page onto the upper half of the SRAM. Writes to the register windows land in an internal write-only control register and a rate register.

One control bit stops DSP writes to the SRAM low byte lane, which keeps a freshly loaded program from being overwritten. A second control bit gates a periodic one-cycle NMI pulse, and the rate register sets its period.

Top module: `shmem_decoder`

## Requirements
- R1: With `bank_hi` low, CPU 0x4000–0x4FFF maps to physical 0x0000–0x0FFF and CPU 0x6000–0x7FFF maps to physical 0x2000–0x3FFF, with `cpu_sram_cs` set while `cpu_rd` or `cpu_wr` is high and `cpu_sram_we` set only on writes.
- R2: With `bank_hi` low, the CPU 1K windows at 0x5000 and 0x5400 assert `cpu_audio_cs` and `cpu_uart_cs`. The windows at 0x5800 (control) and 0x5C00 (rate) write the registers and assert no SRAM or peripheral select.
- R3: With `bank_hi` high, CPU 0x4000–0x7FFF maps to physical 0x4000–0x7FFF, and no peripheral select or register write occurs there.
- R4: DSP 0x4000–0x5FFF maps to physical 0x0000–0x1FFF, and DSP 0x6000–0x67FF maps to physical 0x2000–0x27FF (the same words the CPU reaches at 0x6000–0x67FF). `dsp_sram_we[i]` follows `dsp_wr` and `dsp_be[i]`.
- R5: On the DSP bus, 0x6800 writes the control register, 0x6C00 writes the rate register, 0x7000 asserts `dsp_audio_cs` and 0x7400 asserts `dsp_uart_cs`, each as a 1K window. 0x7800–0x7FFF asserts nothing.
- R6: An address outside 0x4000–0x7FFF asserts no select on either bus. No select or write enable is asserted while both strobes of that bus are low. `*_sram_addr` is 0 whenever the address is not an SRAM address.
- R7: While control bit 0 is 1, `dsp_sram_we[0]` stays 0. `dsp_sram_we[1]`, DSP reads and all CPU access are unaffected.
- R8: While control bit 2 is 0, `nmi` stays 0 (from the cycle after the bit clears).
- R9: While control bit 2 is 1, `nmi` is a one-cycle pulse that repeats every PRESCALE × (rate + 1) clock cycles.
- R10: After reset both registers are 0, so the write protect is off and `nmi` is low.
- R11: Either bus can write either register, using data bits [7:0]. If both buses write the same register in the same cycle, the CPU value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| bank_hi | input | 1 | CPU bank select: page to upper SRAM half |
| dsp_addr | input | 16 | DSP word address |
| dsp_rd | input | 1 | DSP read strobe |
| dsp_wr | input | 1 | DSP write strobe |
| dsp_be | input | 2 | DSP byte-lane enables |
| dsp_wdata | input | 8 | DSP write data, low byte |
| cpu_sram_cs | output | 1 | SRAM select for CPU |
| cpu_sram_we | output | 1 | SRAM write enable for CPU |
| cpu_sram_addr | output | 15 | Physical SRAM address for CPU |
| cpu_audio_cs | output | 1 | Audio peripheral select for CPU |
| cpu_uart_cs | output | 1 | UART select for CPU |
| dsp_sram_cs | output | 1 | SRAM select for DSP |
| dsp_sram_we | output | 2 | Per-lane SRAM write enables for DSP |
| dsp_sram_addr | output | 15 | Physical SRAM address for DSP |
| dsp_audio_cs | output | 1 | Audio peripheral select for DSP |
| dsp_uart_cs | output | 1 | UART select for DSP |
| nmi | output | 1 | Periodic NMI pulse |

## Verification
The decode paths have no state, so a wrong window boundary or a wrong physical offset shows up in the same cycle as a wrong select or address at the ports. Sweeping every 1K window on both buses with the bank select at both levels exposes it at once. A wrong stored control bit shows on the next DSP low-lane write enable, or as a missing or extra NMI pulse within one period. A wrong rate value or wrong write priority shows as a pulse spacing that differs from PRESCALE × (rate + 1) cycles, measured between two consecutive pulses.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
  localparam int ADDR_W  = 16;
  localparam int SRAM_AW = 15;
  localparam int DATA_W  = 8;
  localparam int DSP_LANES = 2;
  localparam logic [1:0] PAGE_ID = 2'b01;   // addr[15:14] of the 0x4000-0x7FFF page
  localparam int WP_BIT  = 0;               // control bit: DSP low-lane write lock
  localparam int NMI_BIT = 2;               // control bit: NMI enable

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_SRAM,
    TGT_AUDIO,
    TGT_UART,
    TGT_CTRL,
    TGT_RATE
  } tgt_e;

  typedef struct packed {
    tgt_e               tgt;
    logic [SRAM_AW-1:0] sram_addr;
  } dec_s;
endpackage

// File: rtl/shmem_cpu_map.sv
module shmem_cpu_map
  import shmem_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              bank_hi,
  output dec_s              dec
);
  logic in_page;
  assign in_page = (addr[ADDR_W-1 -: 2] == PAGE_ID);

  always_comb begin
    dec     = '0;
    dec.tgt = TGT_NONE;
    if (in_page) begin
      if (bank_hi) begin
        dec.tgt       = TGT_SRAM;
        dec.sram_addr = {1'b1, addr[13:0]};
      end else if (addr[13]) begin
        dec.tgt       = TGT_SRAM;
        dec.sram_addr = {2'b01, addr[12:0]};
      end else if (!addr[12]) begin
        dec.tgt       = TGT_SRAM;
        dec.sram_addr = {3'b000, addr[11:0]};
      end else begin
        case (addr[11:10])
          2'd0:    dec.tgt = TGT_AUDIO;
          2'd1:    dec.tgt = TGT_UART;
          2'd2:    dec.tgt = TGT_CTRL;
          default: dec.tgt = TGT_RATE;
        endcase
      end
    end
  end
endmodule

// File: rtl/shmem_dsp_map.sv
module shmem_dsp_map
  import shmem_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output dec_s              dec
);
  logic in_page;
  assign in_page = (addr[ADDR_W-1 -: 2] == PAGE_ID);

  always_comb begin
    dec     = '0;
    dec.tgt = TGT_NONE;
    if (in_page) begin
      if (!addr[13]) begin
        dec.tgt       = TGT_SRAM;
        dec.sram_addr = {2'b00, addr[12:0]};
      end else begin
        case (addr[12:10])
          3'd0, 3'd1: begin
            dec.tgt       = TGT_SRAM;
            dec.sram_addr = {4'b0100, addr[10:0]};
          end
          3'd2:    dec.tgt = TGT_CTRL;
          3'd3:    dec.tgt = TGT_RATE;
          3'd4:    dec.tgt = TGT_AUDIO;
          3'd5:    dec.tgt = TGT_UART;
          default: dec.tgt = TGT_NONE;   // processor-internal space
        endcase
      end
    end
  end
endmodule

// File: rtl/shmem_bus_strobes.sv
module shmem_bus_strobes
  import shmem_pkg::*;
#(
  parameter int LANES = 1
) (
  input  dec_s               dec,
  input  logic               rd,
  input  logic               wr,
  input  logic [LANES-1:0]   be,
  input  logic               lane0_lock,
  output logic               sram_cs,
  output logic [LANES-1:0]   sram_we,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic               audio_cs,
  output logic               uart_cs,
  output logic               ctrl_wr,
  output logic               rate_wr
);
  logic access, sram_hit;
  assign access    = rd | wr;
  assign sram_hit  = (dec.tgt == TGT_SRAM);
  assign sram_cs   = access & sram_hit;
  assign sram_addr = dec.sram_addr;
  assign audio_cs  = access & (dec.tgt == TGT_AUDIO);
  assign uart_cs   = access & (dec.tgt == TGT_UART);
  assign ctrl_wr   = wr & (dec.tgt == TGT_CTRL);
  assign rate_wr   = wr & (dec.tgt == TGT_RATE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_lockable
      assign sram_we[g] = wr & sram_hit & be[g] & ~lane0_lock;
    end else begin : g_plain
      assign sram_we[g] = wr & sram_hit & be[g];
    end
  end
endmodule

// File: rtl/shmem_ctrl_regs.sv
module shmem_ctrl_regs
  import shmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ctrl_wr,
  input  logic              cpu_rate_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              dsp_ctrl_wr,
  input  logic              dsp_rate_wr,
  input  logic [DATA_W-1:0] dsp_wdata,
  output logic              wp_lane0,
  output logic              nmi_en,
  output logic [DATA_W-1:0] rate_q
);
  logic              wp_d, en_d, ctrl_ce, rate_ce;
  logic [DATA_W-1:0] rate_d;

  assign ctrl_ce = cpu_ctrl_wr | dsp_ctrl_wr;
  assign rate_ce = cpu_rate_wr | dsp_rate_wr;

  always_comb begin
    if (cpu_ctrl_wr) begin
      wp_d = cpu_wdata[WP_BIT];
      en_d = cpu_wdata[NMI_BIT];
    end else begin
      wp_d = dsp_wdata[WP_BIT];
      en_d = dsp_wdata[NMI_BIT];
    end
    rate_d = cpu_rate_wr ? cpu_wdata : dsp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_lane0 <= 1'b0;
      nmi_en   <= 1'b0;
    end else if (ctrl_ce) begin
      wp_lane0 <= wp_d;
      nmi_en   <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
    end else if (rate_ce) begin
      rate_q <= rate_d;
    end
  end
endmodule

// File: rtl/shmem_nmi_timer.sv
module shmem_nmi_timer
  import shmem_pkg::*;
#(
  parameter int PRESCALE = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DATA_W-1:0] rate,
  output logic              nmi
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [DATA_W-1:0] div_q, div_d;
  logic              nmi_d, tick;

  assign tick = (pre_q == PRE_LAST);

  always_comb begin
    pre_d = '0;
    div_d = '0;
    nmi_d = 1'b0;
    if (enable) begin
      pre_d = tick ? '0 : pre_q + 1'b1;
      div_d = div_q;
      if (tick) begin
        if (div_q == rate) begin
          div_d = '0;
          nmi_d = 1'b1;
        end else begin
          div_d = div_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
      nmi   <= 1'b0;
    end else begin
      pre_q <= pre_d;
      div_q <= div_d;
      nmi   <= nmi_d;
    end
  end
endmodule

// File: rtl/shmem_decoder.sv
module shmem_decoder
  import shmem_pkg::*;
#(
  parameter int PRESCALE = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic                 cpu_rd,
  input  logic                 cpu_wr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  input  logic                 bank_hi,
  input  logic [ADDR_W-1:0]    dsp_addr,
  input  logic                 dsp_rd,
  input  logic                 dsp_wr,
  input  logic [DSP_LANES-1:0] dsp_be,
  input  logic [DATA_W-1:0]    dsp_wdata,
  output logic                 cpu_sram_cs,
  output logic                 cpu_sram_we,
  output logic [SRAM_AW-1:0]   cpu_sram_addr,
  output logic                 cpu_audio_cs,
  output logic                 cpu_uart_cs,
  output logic                 dsp_sram_cs,
  output logic [DSP_LANES-1:0] dsp_sram_we,
  output logic [SRAM_AW-1:0]   dsp_sram_addr,
  output logic                 dsp_audio_cs,
  output logic                 dsp_uart_cs,
  output logic                 nmi
);
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  dec_s              cpu_dec, dsp_dec;
  logic              cpu_ctrl_wr, cpu_rate_wr, dsp_ctrl_wr, dsp_rate_wr;
  logic              wp_lane0, nmi_en;
  logic [DATA_W-1:0] rate_q;

  shmem_cpu_map u_cpu_map (.addr(cpu_addr), .bank_hi(bank_hi), .dec(cpu_dec));
  shmem_dsp_map u_dsp_map (.addr(dsp_addr), .dec(dsp_dec));

  shmem_bus_strobes #(.LANES(1)) u_cpu_strb (
    .dec(cpu_dec), .rd(cpu_rd), .wr(cpu_wr), .be(1'b1), .lane0_lock(1'b0),
    .sram_cs(cpu_sram_cs), .sram_we(cpu_sram_we), .sram_addr(cpu_sram_addr),
    .audio_cs(cpu_audio_cs), .uart_cs(cpu_uart_cs),
    .ctrl_wr(cpu_ctrl_wr), .rate_wr(cpu_rate_wr)
  );

  shmem_bus_strobes #(.LANES(DSP_LANES)) u_dsp_strb (
    .dec(dsp_dec), .rd(dsp_rd), .wr(dsp_wr), .be(dsp_be), .lane0_lock(wp_lane0),
    .sram_cs(dsp_sram_cs), .sram_we(dsp_sram_we), .sram_addr(dsp_sram_addr),
    .audio_cs(dsp_audio_cs), .uart_cs(dsp_uart_cs),
    .ctrl_wr(dsp_ctrl_wr), .rate_wr(dsp_rate_wr)
  );

  shmem_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .cpu_ctrl_wr(cpu_ctrl_wr), .cpu_rate_wr(cpu_rate_wr), .cpu_wdata(cpu_wdata),
    .dsp_ctrl_wr(dsp_ctrl_wr), .dsp_rate_wr(dsp_rate_wr), .dsp_wdata(dsp_wdata),
    .wp_lane0(wp_lane0), .nmi_en(nmi_en), .rate_q(rate_q)
  );

  shmem_nmi_timer #(.PRESCALE(PRESCALE)) u_nmi (
    .clk(clk), .rst_n(rst_sync_n), .enable(nmi_en), .rate(rate_q), .nmi(nmi)
  );
endmodule

// File: rtl/shmem_decoder_chk.sv
module shmem_decoder_chk
  import shmem_pkg::*;
#(
  parameter int PRESCALE = 256
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    cpu_addr,
  input logic                 bank_hi,
  input logic [ADDR_W-1:0]    dsp_addr,
  input logic                 cpu_sram_cs,
  input logic                 cpu_audio_cs,
  input logic                 cpu_uart_cs,
  input logic                 dsp_sram_cs,
  input logic [DSP_LANES-1:0] dsp_sram_we,
  input logic                 dsp_audio_cs,
  input logic                 dsp_uart_cs,
  input logic                 wp_lane0,
  input logic                 nmi_en,
  input logic                 nmi
);
  p_cpu_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_sram_cs, cpu_audio_cs, cpu_uart_cs}));

  p_bank_hides_periph_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_hi |-> !(cpu_audio_cs || cpu_uart_cs));

  p_dsp_internal_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_addr[15:11] == 5'b01111) |-> !(dsp_sram_cs || dsp_audio_cs || dsp_uart_cs));

  p_cpu_out_of_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] != PAGE_ID) |-> !(cpu_sram_cs || cpu_audio_cs || cpu_uart_cs));

  p_dsp_out_of_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_addr[15:14] != PAGE_ID) |-> !(dsp_sram_cs || dsp_audio_cs || dsp_uart_cs));

  p_lane0_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wp_lane0 |-> !dsp_sram_we[0]);

  p_nmi_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_en |=> !nmi);

  p_nmi_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi && (PRESCALE > 1)) |=> !nmi);
endmodule

bind shmem_decoder shmem_decoder_chk #(.PRESCALE(PRESCALE)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cpu_addr(cpu_addr), .bank_hi(bank_hi),
  .dsp_addr(dsp_addr), .cpu_sram_cs(cpu_sram_cs), .cpu_audio_cs(cpu_audio_cs),
  .cpu_uart_cs(cpu_uart_cs), .dsp_sram_cs(dsp_sram_cs), .dsp_sram_we(dsp_sram_we),
  .dsp_audio_cs(dsp_audio_cs), .dsp_uart_cs(dsp_uart_cs), .wp_lane0(wp_lane0),
  .nmi_en(nmi_en), .nmi(nmi)
);

// File: tb/shmem_decoder_tb_top.sv
module shmem_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRESCALE   = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr, dsp_addr;
  logic        cpu_rd, cpu_wr, bank_hi, dsp_rd, dsp_wr;
  logic [7:0]  cpu_wdata, dsp_wdata;
  logic [1:0]  dsp_be;
  logic        cpu_sram_cs, cpu_sram_we, cpu_audio_cs, cpu_uart_cs;
  logic        dsp_sram_cs, dsp_audio_cs, dsp_uart_cs, nmi;
  logic [1:0]  dsp_sram_we;
  logic [14:0] cpu_sram_addr, dsp_sram_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  shmem_decoder #(.PRESCALE(PRESCALE)) dut_i (.*);

  typedef struct packed {
    logic        c_cs; logic c_we; logic [14:0] c_addr; logic c_aud; logic c_uart;
    logic        d_cs; logic [1:0] d_we; logic [14:0] d_addr; logic d_aud; logic d_uart;
  } obs_t;
  typedef struct { obs_t exp; string tag; } item_t;

  item_t sb[$];
  int    checks = 0, errors = 0;
  bit    prot = 1'b0;

  function automatic item_t model(input int ca, input bit crd, input bit cwr, input bit bk,
                                  input int da, input bit drd, input bit dwr,
                                  input bit [1:0] be, input bit pr);
    item_t it;
    string ct, dt;
    bit    cacc = crd | cwr, dacc = drd | dwr;
    it.exp = '0;
    ct = "R6"; dt = "R6";
    if (ca >= 'h4000 && ca < 'h8000) begin
      if (bk) begin
        it.exp.c_cs = cacc; it.exp.c_addr = 15'(ca); ct = "R3";
      end else if (ca < 'h5000) begin
        it.exp.c_cs = cacc; it.exp.c_addr = 15'(ca - 'h4000); ct = "R1";
      end else if (ca < 'h5400) begin
        it.exp.c_aud = cacc; ct = "R2";
      end else if (ca < 'h5800) begin
        it.exp.c_uart = cacc; ct = "R2";
      end else if (ca < 'h6000) begin
        ct = "R2";
      end else begin
        it.exp.c_cs = cacc; it.exp.c_addr = 15'('h2000 + ca - 'h6000); ct = "R1";
      end
    end
    it.exp.c_we = it.exp.c_cs & cwr;
    if (da >= 'h4000 && da < 'h8000) begin
      if (da < 'h6000) begin
        it.exp.d_cs = dacc; it.exp.d_addr = 15'(da - 'h4000); dt = "R4";
      end else if (da < 'h6800) begin
        it.exp.d_cs = dacc; it.exp.d_addr = 15'('h2000 + da - 'h6000); dt = "R4";
      end else if (da < 'h7000) begin
        dt = "R5";
      end else if (da < 'h7400) begin
        it.exp.d_aud = dacc; dt = "R5";
      end else if (da < 'h7800) begin
        it.exp.d_uart = dacc; dt = "R5";
      end else begin
        dt = "R5";
      end
    end
    it.exp.d_we[1] = it.exp.d_cs & dwr & be[1];
    it.exp.d_we[0] = it.exp.d_cs & dwr & be[0] & !pr;
    if (pr) dt = {dt, " R7"};
    it.tag = {ct, " ", dt};
    return it;
  endfunction

  task automatic drive(input int ca, input bit crd, input bit cwr, input bit [7:0] cwd,
                       input bit bk, input int da, input bit drd, input bit dwr,
                       input bit [1:0] be, input bit [7:0] dwd, input string note);
    item_t it;
    @(posedge clk); #1;
    cpu_addr = 16'(ca); cpu_rd = crd; cpu_wr = cwr; cpu_wdata = cwd; bank_hi = bk;
    dsp_addr = 16'(da); dsp_rd = drd; dsp_wr = dwr; dsp_be = be; dsp_wdata = dwd;
    it = model(ca, crd, cwr, bk, da, drd, dwr, be, prot);
    it.tag = {note, " ", it.tag};
    sb.push_back(it);
  endtask

  task automatic idle();
    drive('h0000, 0, 0, 8'h00, 0, 'h0000, 0, 0, 2'b00, 8'h00, "R6");
  endtask

  task automatic drain();
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pop one expected item per cycle, compare mid-cycle
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      obs_t  o;
      it = sb.pop_front();
      o = '{cpu_sram_cs, cpu_sram_we, cpu_sram_addr, cpu_audio_cs, cpu_uart_cs,
            dsp_sram_cs, dsp_sram_we, dsp_sram_addr, dsp_audio_cs, dsp_uart_cs};
      checks++;
      if (o !== it.exp) begin
        errors++;
        $display("FAIL %s caddr=%h daddr=%h act=%h exp=%h", it.tag, cpu_addr, dsp_addr, o, it.exp);
      end
    end
  end

  task automatic measure(output int per, output int width);
    int t = 0;
    per = 0; width = 0;
    @(negedge clk);
    while (!nmi && t < 2000) begin @(negedge clk); t++; end
    while (nmi && width < 2000) begin width++; per++; @(negedge clk); end
    while (!nmi && per < 2000) begin per++; @(negedge clk); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per, wid, hits;
    rst_n = 1'b0;
    cpu_addr = '0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0; bank_hi = 0;
    dsp_addr = '0; dsp_rd = 0; dsp_wr = 0; dsp_be = '0; dsp_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R10: reset state, NMI quiet and low lane writable
    hits = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (nmi) hits++; end
    check(hits == 0, "R10 nmi after reset", hits, 0);
    drive('h0000, 0, 0, 8'h00, 0, 'h4000, 0, 1, 2'b11, 8'h00, "R10");
    idle(); drain();

    // Sweep every 1K window on both buses, bank at both levels, reads then writes
    for (int bk = 0; bk < 2; bk++) begin
      for (int w = 0; w < 64; w++) begin
        drive(w*1024 + 'h155, 1, 0, 8'h00, bit'(bk), w*1024 + 'h2aa, 1, 0, 2'b11, 8'h00, "sweep");
      end
    end
    for (int w = 16; w < 32; w++) begin
      if (w == 22 || w == 23) continue;   // skip register windows on CPU writes
      drive(w*1024 + 'h3ff, 0, 1, 8'h00, 0, (w == 26 || w == 27) ? 'h4000 : w*1024, 0, 1, 2'b10, 8'h00, "sweep-wr");
    end
    // R6: strobes low assert nothing
    for (int w = 16; w < 32; w++) begin
      drive(w*1024, 0, 0, 8'h00, 0, w*1024, 0, 0, 2'b11, 8'h00, "R6 nostrobe");
    end
    idle(); drain();

    // R7: CPU sets lock bit, DSP low lane blocked, high lane and reads fine
    drive('h5800, 0, 1, 8'h01, 0, 'h0000, 0, 0, 2'b00, 8'h00, "R2 ctrl");
    idle(); prot = 1'b1;
    for (int w = 16; w < 26; w++) begin
      drive('h6000 + w, 0, 1, 8'h00, 0, w*1024 + 'h11, 0, 1, 2'b11, 8'h00, "R7");
      drive('h4000, 1, 0, 8'h00, 1, w*1024 + 'h22, 0, 1, 2'b01, 8'h00, "R7");
      drive('h4000, 0, 0, 8'h00, 0, w*1024 + 'h33, 1, 0, 2'b11, 8'h00, "R7");
    end
    // R11: DSP clears the control register
    drive('h0000, 0, 0, 8'h00, 0, 'h6800, 0, 1, 2'b11, 8'h00, "R11 ctrl");
    idle(); prot = 1'b0;
    drive('h0000, 0, 0, 8'h00, 0, 'h4abc, 0, 1, 2'b11, 8'h00, "R11 R7 unlocked");
    idle(); drain();

    // R9: DSP writes rate 2, CPU enables NMI
    drive('h0000, 0, 0, 8'h00, 0, 'h6c00, 0, 1, 2'b01, 8'd2, "R11 rate");
    drive('h5800, 0, 1, 8'h04, 0, 'h0000, 0, 0, 2'b00, 8'h00, "R8 en");
    idle(); drain();
    measure(per, wid);
    check(per == PRESCALE*3, "R9 period rate2", per, PRESCALE*3);
    check(wid == 1, "R9 pulse width", wid, 1);
    measure(per, wid);
    check(per == PRESCALE*3, "R9 period repeat", per, PRESCALE*3);

    // R8: disable, NMI stays low
    drive('h5800, 0, 1, 8'h00, 0, 'h0000, 0, 0, 2'b00, 8'h00, "R8 dis");
    idle(); drain();
    hits = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (nmi) hits++; end
    check(hits == 0, "R8 nmi disabled", hits, 0);

    // R11: simultaneous rate writes, CPU value 1 kept over DSP value 5
    drive('h5c00, 0, 1, 8'd1, 0, 'h6c00, 0, 1, 2'b01, 8'd5, "R11 both");
    drive('h0000, 0, 0, 8'h00, 0, 'h6800, 0, 1, 2'b01, 8'h04, "R11 en");
    idle(); drain();
    measure(per, wid);
    check(per == PRESCALE*2, "R11 cpu priority", per, PRESCALE*2);
    check(wid == 1, "R9 pulse width rate1", wid, 1);

    // R11: simultaneous control writes, CPU disable wins over DSP enable
    drive('h5800, 0, 1, 8'h00, 0, 'h6800, 0, 1, 2'b01, 8'h04, "R11 ctrl both");
    idle(); drain();
    hits = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (nmi) hits++; end
    check(hits == 0, "R11 ctrl cpu priority", hits, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule